// File: doc/BRIEF.md
# Repeating Block Copy Sequencer

This block moves a run of bytes from one region of an 8-bit-data, 16-bit-address memory to another. A start pulse loads the source pointer, the destination pointer and a 16-bit byte count. The block then runs a fixed-length iteration for each byte. The read goes out on the bus in the third machine cycle of the iteration and the write goes out in the fourth. After the write, both pointers step up by one and the count steps down by one. Every iteration that leaves a non-zero count runs one more machine cycle and starts over. The iteration that brings the count to zero ends early and raises a done flag.

Between repeating iterations the block samples an interrupt request. If the request is high there, the copy stops with its pointers and count already updated and raises an interrupted flag. Software reads the three registers back and issues a new start with them, and the copy carries on from the byte after the last one moved. A starting count of zero is treated as 65536 bytes, because the first decrement wraps it. The memory port is a plain synchronous read/write port whose read data returns one clock after the read strobe.

Top module: `blk_copy_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, busy, done, intr_flag, mem_rd and mem_wr are all 0.
- R2: A start pulse while idle loads src_init, dst_init and cnt_init into src_ptr, dst_ptr and byte_cnt, and busy is 1 from the next cycle. A start pulse while busy has no effect on the pointers, the count or the timing.
- R3: Clocks of an iteration are counted from 0, where 0 is the first busy cycle of that iteration. mem_rd is high during iteration clock 8 with mem_addr equal to the source pointer. mem_wr is high during iteration clock 11 with mem_addr equal to the destination pointer and mem_wdata equal to the byte that was read.
- R4: From iteration clock 16 onward, src_ptr and dst_ptr are one higher and byte_cnt is one lower. Every pointer and the count wrap modulo 65536 (for example 0xFFFF+1 gives 0x0000).
- R5: An iteration that leaves a non-zero count lasts 21 clocks (machine cycles of 4, 4, 3, 5 and 5). The iteration that leaves a count of zero lasts 16 clocks. An uninterrupted copy of N bytes keeps busy high for 21·(N−1)+16 cycles.
- R6: A starting count of 0 does not end the copy after the first byte: byte_cnt becomes 0xFFFF and copying continues.
- R7: irq_req is sampled only on the last clock (clock 20) of a repeating iteration. If it is high there, busy falls, intr_flag rises and the updated pointers and count are kept. A later start with those values completes the remaining bytes.
- R8: done rises when the final byte's iteration ends. done and intr_flag are never high together, and both hold until the next accepted start clears them.
- R9: mem_rd and mem_wr are never high together, and neither is high while busy is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a copy with the init values (ignored while busy) |
| src_init | input | 16 | First source address |
| dst_init | input | 16 | First destination address |
| cnt_init | input | 16 | Byte count, 0 meaning 65536 |
| irq_req | input | 1 | Interrupt request, sampled between repeating iterations |
| mem_rdata | input | 8 | Read data, valid one clock after mem_rd |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Copy completed |
| intr_flag | output | 1 | Copy stopped by an interrupt |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| byte_cnt | output | 16 | Bytes remaining |

## Verification
If the iteration clock counter drifts, the bus strobes land on the wrong cycle within the same iteration, and busy falls at the wrong clock. The per-clock comparison catches either within one cycle. If the pointers or the count update wrongly, the error shows at the first bus access of the next iteration, through mem_addr, and it also shows directly on src_ptr, dst_ptr and byte_cnt from iteration clock 16. If the captured data is wrong, mem_wdata differs from the byte just read at the next write strobe, three clocks after that read. A bad end or interrupt decision shows on busy, done and intr_flag on the very cycle after the decision edge.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  // Control state of the copy sequencer.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bcs_state_e;

  // Indices of the iteration-clock strobes produced by the timer.
  localparam int EV_RD_Q = 0;  // clock before the read strobe
  localparam int EV_CAP  = 1;  // read data returns
  localparam int EV_WR_Q = 2;  // clock before the write strobe
  localparam int EV_UPD  = 3;  // pointer/count update, end of final pass
  localparam int EV_END  = 4;  // last clock of a repeating pass
  localparam int EV_NUM  = 5;

endpackage

// File: rtl/bcs_timer.sv
module bcs_timer #(
  parameter int                  TW     = 5,
  parameter int                  NEV    = 5,
  parameter logic [NEV*TW-1:0]   EV_AT  = '0,
  parameter logic [TW-1:0]       T_LAST = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  output logic [TW-1:0]  t,
  output logic [NEV-1:0] hit
);

  // Clock index inside the current iteration; parked at 0 while idle.
  always_ff @(posedge clk) begin
    if (rst) begin
      t <= '0;
    end else if (!run || t == T_LAST) begin
      t <= '0;
    end else begin
      t <= t + TW'(1);
    end
  end

  // One strobe per scheduled event of the iteration.
  for (genvar i = 0; i < NEV; i++) begin : g_ev
    assign hit[i] = run && (t == EV_AT[i*TW +: TW]);
  end

endmodule

// File: rtl/bcs_ptrs.sv
module bcs_ptrs #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] cnt_i,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [AW-1:0] cnt,
  output logic          last
);

  always_ff @(posedge clk) begin
    if (rst) begin
      src <= '0;
      dst <= '0;
      cnt <= '0;
    end else if (load) begin
      src <= src_i;
      dst <= dst_i;
      cnt <= cnt_i;
    end else if (step) begin
      // Modular arithmetic: pointers wrap at the top of the space and a
      // zero count wraps to all ones, which gives the full-space copy.
      src <= src + AW'(1);
      dst <= dst + AW'(1);
      cnt <= cnt - AW'(1);
    end
  end

  // The pass now running is the final one when one byte remains.
  assign last = (cnt == AW'(1));

endmodule

// File: rtl/bcs_bus.sv
module bcs_bus #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_go,
  input  logic          cap,
  input  logic          wr_go,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata
);

  // All bus outputs are registered; strobes arrive one clock early.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_rd <= rd_go;
      mem_wr <= wr_go;
      if (rd_go) begin
        mem_addr <= src;
      end else if (wr_go) begin
        mem_addr <= dst;
      end
      // The write-data register doubles as the holding register.
      if (cap) begin
        mem_wdata <= rdata;
      end
    end
  end

endmodule

// File: rtl/blk_copy_seq.sv
module blk_copy_seq
  import bcs_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int MC1_LEN = 4,
  parameter int MC2_LEN = 4,
  parameter int MC3_LEN = 3,
  parameter int MC4_LEN = 5,
  parameter int MC5_LEN = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic [AW-1:0] cnt_init,
  input  logic          irq_req,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          done,
  output logic          intr_flag,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [AW-1:0] byte_cnt
);

  // Iteration schedule derived from the machine-cycle lengths.
  localparam int ITER_T = MC1_LEN + MC2_LEN + MC3_LEN + MC4_LEN + MC5_LEN;
  localparam int TW     = $clog2(ITER_T);
  localparam int RD_T   = MC1_LEN + MC2_LEN;          // first clock of MC3
  localparam int WR_T   = RD_T + MC3_LEN;             // first clock of MC4
  localparam int UPD_T  = WR_T + MC4_LEN - 1;         // last clock of MC4
  localparam int END_T  = ITER_T - 1;                 // last clock of MC5

  localparam logic [TW-1:0] T_RDQ = TW'(RD_T - 1);
  localparam logic [TW-1:0] T_CAP = TW'(RD_T + 1);
  localparam logic [TW-1:0] T_WRQ = TW'(WR_T - 1);
  localparam logic [TW-1:0] T_UPD = TW'(UPD_T);
  localparam logic [TW-1:0] T_END = TW'(END_T);
  localparam logic [EV_NUM*TW-1:0] EV_AT = {T_END, T_UPD, T_WRQ, T_CAP, T_RDQ};

  bcs_state_e        state_q;
  logic [TW-1:0]     t_q;
  logic [EV_NUM-1:0] hit;
  logic              load;
  logic              last;

  assign busy = (state_q == ST_RUN);
  assign load = (state_q == ST_IDLE) && start;

  bcs_timer #(
    .TW    (TW),
    .NEV   (EV_NUM),
    .EV_AT (EV_AT),
    .T_LAST(T_END)
  ) u_timer (
    .clk(clk),
    .rst(rst),
    .run(busy),
    .t  (t_q),
    .hit(hit)
  );

  bcs_ptrs #(
    .AW(AW)
  ) u_ptrs (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .step (hit[EV_UPD]),
    .src_i(src_init),
    .dst_i(dst_init),
    .cnt_i(cnt_init),
    .src  (src_ptr),
    .dst  (dst_ptr),
    .cnt  (byte_cnt),
    .last (last)
  );

  bcs_bus #(
    .AW(AW),
    .DW(DW)
  ) u_bus (
    .clk      (clk),
    .rst      (rst),
    .rd_go    (hit[EV_RD_Q]),
    .cap      (hit[EV_CAP]),
    .wr_go    (hit[EV_WR_Q]),
    .src      (src_ptr),
    .dst      (dst_ptr),
    .rdata    (mem_rdata),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_wdata(mem_wdata)
  );

  // Control: accept start, end on the final pass, stop on a sampled interrupt.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      done      <= 1'b0;
      intr_flag <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q   <= ST_RUN;
            done      <= 1'b0;
            intr_flag <= 1'b0;
          end
        end
        ST_RUN: begin
          if (hit[EV_UPD] && last) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end else if (hit[EV_END] && irq_req) begin
            state_q   <= ST_IDLE;
            intr_flag <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          intr_flag,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] src_ptr,
  input logic [AW-1:0] dst_ptr,
  input logic [AW-1:0] byte_cnt
);

  // R9: one bus direction at a time
  p_bus_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R9: bus quiet while idle
  p_bus_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd && !mem_wr));

  // R2: an accepted start makes the block busy on the next cycle
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R2: without a start, idle registers stay put
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(src_ptr) && $stable(dst_ptr) && $stable(byte_cnt)));

  // R4: while running, the three registers move only in lockstep by one
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    busy |=> ((src_ptr == $past(src_ptr)) && (dst_ptr == $past(dst_ptr)) &&
              (byte_cnt == $past(byte_cnt))) ||
             ((src_ptr == $past(src_ptr) + AW'(1)) && (dst_ptr == $past(dst_ptr) + AW'(1)) &&
              (byte_cnt == $past(byte_cnt) - AW'(1))));

  // R3: read addresses the source, write addresses the destination
  p_rd_addr_r3: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (mem_addr == src_ptr));
  p_wr_addr_r3: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_addr == dst_ptr));

  // R8: completion flags exclusive and only while idle
  p_flags_r8: assert property (@(posedge clk) disable iff (rst)
    !(done && intr_flag));
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (done || intr_flag) |-> !busy);

  // R7: an interrupt stop always leaves bytes outstanding
  p_intr_left_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(intr_flag) |-> (byte_cnt != '0));

endmodule

bind blk_copy_seq bcs_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .intr_flag(intr_flag),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_addr (mem_addr),
  .src_ptr  (src_ptr),
  .dst_ptr  (dst_ptr),
  .byte_cnt (byte_cnt)
);

// File: tb/blk_copy_seq_tb.sv
module blk_copy_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] src_init = '0, dst_init = '0, cnt_init = '0;
  logic        irq_req = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic        busy, done, intr_flag;
  logic [15:0] src_ptr, dst_ptr, byte_cnt;

  always #4 clk = ~clk;  // 125 MHz

  blk_copy_seq u_dut (
    .clk(clk), .rst(rst), .start(start),
    .src_init(src_init), .dst_init(dst_init), .cnt_init(cnt_init),
    .irq_req(irq_req), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done), .intr_flag(intr_flag),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .byte_cnt(byte_cnt)
  );

  int checks = 0;
  int failures = 0;
  int cycle = 0;
  int busy_cyc = 0;
  logic [7:0] exp_byte = '0;

  // Sparse memory: untouched locations hold a fixed pattern of the address.
  logic [7:0] mem [logic [15:0]];

  function automatic logic [7:0] orig(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rd_byte(input logic [15:0] a);
    if (mem.exists(a)) return mem[a];
    return orig(a);
  endfunction

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] = mem_wdata;
    if (mem_rd) mem_rdata <= rd_byte(mem_addr);
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: iteration clock count and register effects.
  logic        m_busy = 0, m_done = 0, m_intr = 0, m_rd = 0, m_wr = 0;
  logic [15:0] m_src = 0, m_dst = 0, m_cnt = 0, m_addr = 0;
  int          m_t = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_intr = 0; m_rd = 0; m_wr = 0;
      m_src = 0; m_dst = 0; m_cnt = 0; m_t = 0;
    end else begin
      logic rd_n, wr_n;
      rd_n = 0; wr_n = 0;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_done = 0; m_intr = 0; m_t = 0;
          m_src = src_init; m_dst = dst_init; m_cnt = cnt_init;
        end
      end else begin
        if (m_t == 7)  begin rd_n = 1; m_addr = m_src; end
        if (m_t == 10) begin wr_n = 1; m_addr = m_dst; end
        if (m_t == 15) begin
          m_src = m_src + 16'd1; m_dst = m_dst + 16'd1; m_cnt = m_cnt - 16'd1;
          if (m_cnt == 16'd0) begin m_busy = 0; m_done = 1; end
          m_t = m_t + 1;
        end else if (m_t == 20) begin
          if (irq_req) begin m_busy = 0; m_intr = 1; end
          m_t = 0;
        end else begin
          m_t = m_t + 1;
        end
      end
      m_rd = rd_n; m_wr = wr_n;
    end
  end

  // Clock-by-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk("R5", "busy", 32'(busy), 32'(m_busy));
      chk("R8", "done", 32'(done), 32'(m_done));
      chk("R7", "intr_flag", 32'(intr_flag), 32'(m_intr));
      chk("R3", "mem_rd", 32'(mem_rd), 32'(m_rd));
      chk("R3", "mem_wr", 32'(mem_wr), 32'(m_wr));
      chk("R4", "src_ptr", 32'(src_ptr), 32'(m_src));
      chk("R4", "dst_ptr", 32'(dst_ptr), 32'(m_dst));
      chk("R4", "byte_cnt", 32'(byte_cnt), 32'(m_cnt));
      if (m_rd || m_wr) chk("R3", "mem_addr", 32'(mem_addr), 32'(m_addr));
      if (mem_rd) exp_byte = rd_byte(mem_addr);
      if (mem_wr) chk("R3", "mem_wdata", 32'(mem_wdata), 32'(exp_byte));
      if (busy) busy_cyc++;
    end
  end

  always @(posedge clk) begin
    cycle++;
    if (cycle > 150000) begin
      failures++;
      $display("FAIL watchdog R5 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Start a copy and wait for busy to fall. irq_k / extra_k are the busy
  // cycle indices at which to raise the interrupt or pulse a stray start.
  task automatic run_copy(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                          input int irq_k, input int extra_k, output int cyc);
    int k;
    @(negedge clk);
    busy_cyc = 0;
    start = 1; src_init = s; dst_init = d; cnt_init = c;
    @(negedge clk);
    start = 0;
    k = 0;
    while (busy) begin
      if (k == irq_k) irq_req = 1;
      if (k == extra_k) begin
        start = 1; src_init = 16'h3333; dst_init = 16'h3333; cnt_init = 16'd9;
      end else begin
        start = 0;
      end
      @(negedge clk);
      k++;
    end
    irq_req = 0;
    start = 0;
    cyc = busy_cyc;
  endtask

  task automatic chk_copy(input string req, input logic [15:0] s, input logic [15:0] d, input int n);
    for (int i = 0; i < n; i++)
      chk(req, "dest byte", 32'(rd_byte(d + 16'(i))), 32'(orig(s + 16'(i))));
  endtask

  initial begin
    int cyc;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "busy after reset", 32'(busy), 0);
    chk("R1", "done after reset", 32'(done), 0);
    chk("R1", "intr after reset", 32'(intr_flag), 0);
    chk("R1", "bus strobes after reset", 32'({mem_rd, mem_wr}), 0);

    // Single byte: final pass only (R5, R3, R8)
    run_copy(16'h1000, 16'h4000, 16'd1, -1, -1, cyc);
    chk("R5", "cycles N=1", 32'(cyc), 32'd16);
    chk("R8", "done N=1", 32'(done), 1);
    chk_copy("R3", 16'h1000, 16'h4000, 1);

    // Five bytes: 21*4+16
    run_copy(16'h1100, 16'h4100, 16'd5, -1, -1, cyc);
    chk("R5", "cycles N=5", 32'(cyc), 32'd100);
    chk("R4", "src after N=5", 32'(src_ptr), 32'h1105);
    chk_copy("R3", 16'h1100, 16'h4100, 5);

    // Source pointer wrap (R4)
    run_copy(16'hFFFE, 16'h5000, 16'd4, -1, -1, cyc);
    chk("R4", "src wrapped", 32'(src_ptr), 32'h0002);
    chk_copy("R4", 16'hFFFE, 16'h5000, 4);

    // Destination pointer wrap (R4)
    run_copy(16'h2000, 16'hFFFE, 16'd3, -1, -1, cyc);
    chk("R4", "dst wrapped", 32'(dst_ptr), 32'h0001);
    chk_copy("R4", 16'h2000, 16'hFFFE, 3);

    // Stray start while busy is ignored (R2)
    run_copy(16'h1200, 16'h4200, 16'd3, -1, 30, cyc);
    chk("R2", "cycles with stray start", 32'(cyc), 32'd58);
    chk("R2", "src with stray start", 32'(src_ptr), 32'h1203);
    chk_copy("R2", 16'h1200, 16'h4200, 3);

    // Interrupt after the second byte, then resume (R7)
    run_copy(16'h1300, 16'h4300, 16'd6, 25, -1, cyc);
    chk("R7", "cycles to interrupt", 32'(cyc), 32'd42);
    chk("R7", "intr_flag", 32'(intr_flag), 1);
    chk("R7", "count kept", 32'(byte_cnt), 32'd4);
    chk("R7", "src kept", 32'(src_ptr), 32'h1302);
    run_copy(src_ptr, dst_ptr, byte_cnt, -1, -1, cyc);
    chk("R7", "resume cycles", 32'(cyc), 32'd79);
    chk("R8", "done after resume", 32'(done), 1);
    chk("R8", "intr cleared", 32'(intr_flag), 0);
    chk_copy("R7", 16'h1300, 16'h4300, 6);

    // Zero count wraps and keeps going (R6), stopped by interrupt
    run_copy(16'h1400, 16'h4400, 16'd0, 30, -1, cyc);
    chk("R6", "cycles zero count", 32'(cyc), 32'd42);
    chk("R6", "count wrapped", 32'(byte_cnt), 32'hFFFE);
    chk("R6", "not done", 32'(done), 0);
    chk_copy("R6", 16'h1400, 16'h4400, 2);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule